// File: doc/BRIEF.md
# Epoch-Timed Switch Port Transfer Serializer

This block sits between a switch port's packet buffering and a point-to-point fabric data link. On the send side it collects two 512-bit blocks into one 1024-bit transfer unit and adds per-word parity and a small control word. It then spreads the resulting 1200-bit unit over a 75-line bus in the 16 ticks of one epoch. A unit may wait half-filled for any number of epochs until its second block arrives. It is launched only at an epoch boundary, and only when the fabric's grant input is high in that boundary cycle.

On the receive side the block takes 16 consecutive enabled beats from the incoming 75-line bus and rebuilds the unit. It checks every word's parity and either delivers the payload with its control fields or flags an error and drops the unit. A free-running 16-tick counter marks each epoch boundary with a strobe. This strobe lets the block line up with an allocator that runs at half the data clock rate.

Blocks enter through a valid/ready stream. A block is taken on any rising edge where both `blk_valid` and `blk_ready` are high. The source must hold its data steady while valid is high and ready is low. The received-unit output is a one-cycle pulse with no ready, because a line that is already running cannot be stalled.

Top module: `xs_port_serdes`

## Requirements
- R1: `epoch_start` is high in the first cycle after reset release and then in exactly one cycle out of every 16, because it marks tick value 0 of a 4-bit wrapping counter.
- R2: `blk_ready` is high while fewer than two blocks are held. After the second block is accepted it stays low until that unit is launched, however long the grant is withheld.
- R3: A unit is launched only when both blocks are held and `grant` is high in an `epoch_start` cycle. Otherwise `line_out_en` stays low.
- R4: After a launch, `line_out_en` is high for exactly 16 consecutive cycles, starting in the cycle after the `epoch_start` cycle. Beat k (k = 0..15) carries unit bits [75k+74 : 75k].
- R5: Unit layout: the first block goes in bits 511:0 and the second in bits 1023:512. Bit 1024+i is the XOR (even parity) of payload word i, bits [64i+63 : 64i]. Bits 1055:1040 hold the control word: bit 0 valid = 1, bit 1 last, bits 5:2 source id, bits 9:6 destination id, and the other bits 0. Bits 1199:1056 are 0. Last, source and destination are taken with the second block.
- R6: The two holding slots are freed at the launch edge. A unit that completes during a transmission therefore goes out in the very next epoch, and back-to-back units keep `line_out_en` high without a gap.
- R7: The receiver treats 16 consecutive beats with `line_in_en` high as one unit. One cycle after the last beat, if all parity bits match and the valid bit is set, `rx_valid` pulses for one cycle with the payload, last, source and destination.
- R8: If any parity bit of a received unit mismatches, `rx_err` pulses instead and `rx_valid` stays low, so the unit is dropped.
- R9: If `line_in_en` drops before 16 beats, the partial beats are discarded and the next enabled beat starts a new unit.
- R10: During reset `blk_ready` is high, `line_out_en`, `rx_valid` and `rx_err` are low, and whenever `line_out_en` is low `line_out` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | Block offered |
| blk_ready | output | 1 | Block can be accepted |
| blk_data | input | 512 | Block payload |
| blk_last | input | 1 | Last-unit flag, taken with second block |
| blk_src | input | 4 | Source id, taken with second block |
| blk_dst | input | 4 | Destination id, taken with second block |
| grant | input | 1 | Transfer allowed this epoch, sampled at epoch start |
| epoch_start | output | 1 | Epoch boundary strobe |
| line_out | output | 75 | Outgoing data lines |
| line_out_en | output | 1 | Outgoing beat valid |
| line_in | input | 75 | Incoming data lines |
| line_in_en | input | 1 | Incoming beat valid |
| rx_valid | output | 1 | Received unit good, one-cycle pulse |
| rx_err | output | 1 | Received unit failed parity, one-cycle pulse |
| rx_payload | output | 1024 | Received payload |
| rx_last | output | 1 | Received last flag |
| rx_src | output | 4 | Received source id |
| rx_dst | output | 4 | Received destination id |

## Verification
The bench builds the block with its default geometry: 75 lanes, 16 ticks, 512-bit blocks, 64-bit parity words and 4-bit ids. Every beat therefore crosses the real boundaries between payload, parity, control and padding, and one lane flip lands in payload words as well as in the control field. Looping the send side back into the receive side lets one stream of units exercise layout, epoch alignment, back-to-back launch and parity checking together. A separately driven input path covers truncated bursts.

// File: rtl/xs_pkg.sv
package xs_pkg;
  // control word geometry inside the auxiliary field
  localparam int CTRL_W     = 16;
  localparam int CTRL_VALID = 0;
  localparam int CTRL_LAST  = 1;
  localparam int CTRL_SRC   = 2;
endpackage

// File: rtl/xs_epoch_timer.sv
module xs_epoch_timer #(
  parameter int TICKS = 16,
  localparam int TW = $clog2(TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] tick,
  output logic          epoch_start
);
  always_ff @(posedge clk) begin
    if (!rst_n)                       tick <= '0;
    else if (tick == TW'(TICKS - 1))  tick <= '0;
    else                              tick <= tick + 1'b1;
  end

  assign epoch_start = (tick == '0);
endmodule

// File: rtl/xs_tx_packer.sv
module xs_tx_packer
  import xs_pkg::*;
#(
  parameter int LANES     = 75,
  parameter int TICKS     = 16,
  parameter int BLK_BITS  = 512,
  parameter int WORD_BITS = 64,
  parameter int ID_W      = 4,
  localparam int UNIT = LANES * TICKS,
  localparam int PAY  = 2 * BLK_BITS,
  localparam int NW   = PAY / WORD_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                blk_valid,
  output logic                blk_ready,
  input  logic [BLK_BITS-1:0] blk_data,
  input  logic                blk_last,
  input  logic [ID_W-1:0]     blk_src,
  input  logic [ID_W-1:0]     blk_dst,
  input  logic                grant,
  input  logic                epoch_start,
  output logic [LANES-1:0]    line_out,
  output logic                line_out_en
);
  logic [1:0]          fill;
  logic [BLK_BITS-1:0] slot_lo, slot_hi;
  logic                last_q;
  logic [ID_W-1:0]     src_q, dst_q;
  logic [PAY-1:0]      pay;
  logic [NW-1:0]       par;
  logic [CTRL_W-1:0]   ctrl;
  logic [UNIT-1:0]     unit, shreg;
  logic                accept, launch;

  assign blk_ready = (fill != 2'd2);
  assign accept    = blk_valid && blk_ready;
  assign launch    = epoch_start && grant && (fill == 2'd2);
  assign pay       = {slot_hi, slot_lo};

  for (genvar w = 0; w < NW; w++) begin : g_par
    assign par[w] = ^pay[w*WORD_BITS +: WORD_BITS];
  end

  always_comb begin
    ctrl = '0;
    ctrl[CTRL_VALID]           = 1'b1;
    ctrl[CTRL_LAST]            = last_q;
    ctrl[CTRL_SRC +: ID_W]     = src_q;
    ctrl[CTRL_SRC+ID_W +: ID_W] = dst_q;
    unit = '0;
    unit[PAY-1:0]              = pay;
    unit[PAY +: NW]            = par;
    unit[PAY+NW +: CTRL_W]     = ctrl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill        <= '0;
      slot_lo     <= '0;
      slot_hi     <= '0;
      last_q      <= 1'b0;
      src_q       <= '0;
      dst_q       <= '0;
      shreg       <= '0;
      line_out    <= '0;
      line_out_en <= 1'b0;
    end else begin
      if (launch)      fill <= '0;
      else if (accept) fill <= fill + 2'd1;

      if (accept && fill == 2'd0) slot_lo <= blk_data;
      if (accept && fill == 2'd1) begin
        slot_hi <= blk_data;
        last_q  <= blk_last;
        src_q   <= blk_src;
        dst_q   <= blk_dst;
      end

      if (epoch_start) begin
        line_out_en <= launch;
        if (launch) begin
          line_out <= unit[LANES-1:0];
          shreg    <= unit >> LANES;
        end else begin
          line_out <= '0;
        end
      end else if (line_out_en) begin
        line_out <= shreg[LANES-1:0];
        shreg    <= shreg >> LANES;
      end
    end
  end
endmodule

// File: rtl/xs_rx_unpacker.sv
module xs_rx_unpacker
  import xs_pkg::*;
#(
  parameter int LANES     = 75,
  parameter int TICKS     = 16,
  parameter int BLK_BITS  = 512,
  parameter int WORD_BITS = 64,
  parameter int ID_W      = 4,
  localparam int UNIT = LANES * TICKS,
  localparam int PAY  = 2 * BLK_BITS,
  localparam int NW   = PAY / WORD_BITS,
  localparam int TW   = $clog2(TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] line_in,
  input  logic             line_in_en,
  output logic             rx_valid,
  output logic             rx_err,
  output logic [PAY-1:0]   rx_payload,
  output logic             rx_last,
  output logic [ID_W-1:0]  rx_src,
  output logic [ID_W-1:0]  rx_dst
);
  logic [UNIT-1:0]   rxsh;
  logic [TW-1:0]     beat;
  logic              done_q;
  logic [NW-1:0]     par_calc;
  logic [CTRL_W-1:0] ctrl;
  logic              bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxsh   <= '0;
      beat   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= line_in_en && (beat == TW'(TICKS - 1));
      if (line_in_en) begin
        rxsh <= {line_in, rxsh[UNIT-1:LANES]};
        beat <= (beat == TW'(TICKS - 1)) ? '0 : beat + 1'b1;
      end else begin
        beat <= '0;
      end
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_chk
    assign par_calc[w] = ^rxsh[w*WORD_BITS +: WORD_BITS];
  end

  assign ctrl       = rxsh[PAY+NW +: CTRL_W];
  assign bad        = (par_calc != rxsh[PAY +: NW]);
  assign rx_err     = done_q && bad;
  assign rx_valid   = done_q && !bad && ctrl[CTRL_VALID];
  assign rx_payload = rxsh[PAY-1:0];
  assign rx_last    = ctrl[CTRL_LAST];
  assign rx_src     = ctrl[CTRL_SRC +: ID_W];
  assign rx_dst     = ctrl[CTRL_SRC+ID_W +: ID_W];
endmodule

// File: rtl/xs_port_serdes.sv
module xs_port_serdes #(
  parameter int LANES     = 75,
  parameter int TICKS     = 16,
  parameter int BLK_BITS  = 512,
  parameter int WORD_BITS = 64,
  parameter int ID_W      = 4,
  localparam int PAY = 2 * BLK_BITS,
  localparam int TW  = $clog2(TICKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                blk_valid,
  output logic                blk_ready,
  input  logic [BLK_BITS-1:0] blk_data,
  input  logic                blk_last,
  input  logic [ID_W-1:0]     blk_src,
  input  logic [ID_W-1:0]     blk_dst,
  input  logic                grant,
  output logic                epoch_start,
  output logic [LANES-1:0]    line_out,
  output logic                line_out_en,
  input  logic [LANES-1:0]    line_in,
  input  logic                line_in_en,
  output logic                rx_valid,
  output logic                rx_err,
  output logic [PAY-1:0]      rx_payload,
  output logic                rx_last,
  output logic [ID_W-1:0]     rx_src,
  output logic [ID_W-1:0]     rx_dst
);
  logic [TW-1:0] tick;

  xs_epoch_timer #(.TICKS(TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .epoch_start(epoch_start)
  );

  xs_tx_packer #(
    .LANES(LANES), .TICKS(TICKS), .BLK_BITS(BLK_BITS),
    .WORD_BITS(WORD_BITS), .ID_W(ID_W)
  ) u_tx (
    .clk(clk), .rst_n(rst_n),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data),
    .blk_last(blk_last), .blk_src(blk_src), .blk_dst(blk_dst),
    .grant(grant), .epoch_start(epoch_start),
    .line_out(line_out), .line_out_en(line_out_en)
  );

  xs_rx_unpacker #(
    .LANES(LANES), .TICKS(TICKS), .BLK_BITS(BLK_BITS),
    .WORD_BITS(WORD_BITS), .ID_W(ID_W)
  ) u_rx (
    .clk(clk), .rst_n(rst_n),
    .line_in(line_in), .line_in_en(line_in_en),
    .rx_valid(rx_valid), .rx_err(rx_err), .rx_payload(rx_payload),
    .rx_last(rx_last), .rx_src(rx_src), .rx_dst(rx_dst)
  );
endmodule

// File: rtl/xs_port_serdes_chk.sv
module xs_port_serdes_chk #(
  parameter int LANES = 75,
  parameter int TICKS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             blk_valid,
  input logic             blk_ready,
  input logic             grant,
  input logic             epoch_start,
  input logic [LANES-1:0] line_out,
  input logic             line_out_en,
  input logic             rx_valid,
  input logic             rx_err
);
  int gap, run;
  logic seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= 0;
      run  <= 0;
      seen <= 1'b0;
    end else begin
      if (epoch_start) begin
        gap  <= 0;
        seen <= 1'b1;
      end else begin
        gap <= gap + 1;
      end
      if (!line_out_en)          run <= 0;
      else if (run == TICKS - 1) run <= 0;
      else                       run <= run + 1;
    end
  end

  // R1
  epoch_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && gap == TICKS - 1) |-> epoch_start);

  // R1
  epoch_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && epoch_start) |-> gap == TICKS - 1);

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blk_ready) |-> $past(blk_valid));

  // R3
  launch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_out_en) |-> ($past(grant) && $past(epoch_start)));

  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_out_en) |-> $past(run) == TICKS - 1);

  // R8
  rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_err));

  // R10
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_out_en |-> line_out == '0);
endmodule

bind xs_port_serdes xs_port_serdes_chk #(.LANES(LANES), .TICKS(TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_ready(blk_ready),
  .grant(grant), .epoch_start(epoch_start), .line_out(line_out),
  .line_out_en(line_out_en), .rx_valid(rx_valid), .rx_err(rx_err)
);

// File: tb/test_xs_port_serdes.sv
`timescale 1ns/1ps
module test_xs_port_serdes;
  localparam int LANES = 75;
  localparam int TICKS = 16;
  localparam int UNIT  = LANES * TICKS;
  localparam int BLK   = 512;
  localparam int PAY   = 1024;

  typedef struct packed {
    logic           err;
    logic           last;
    logic [3:0]     src;
    logic [3:0]     dst;
    logic [PAY-1:0] pay;
  } rx_item_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             blk_valid, blk_ready, blk_last, grant, epoch_start;
  logic [BLK-1:0]   blk_data;
  logic [3:0]       blk_src, blk_dst;
  logic [LANES-1:0] line_out, line_in, flip, man_data;
  logic             line_out_en, line_in_en, man_en, use_loop;
  logic             rx_valid, rx_err, rx_last;
  logic [PAY-1:0]   rx_payload;
  logic [3:0]       rx_src, rx_dst;

  int checks = 0;
  int errors = 0;
  logic [UNIT-1:0] tx_q[$];
  rx_item_t        rx_q[$];
  int en_cycles = 0, cur_run = 0, max_run = 0;

  always #10 clk = ~clk;

  assign line_in    = use_loop ? (line_out ^ flip) : man_data;
  assign line_in_en = use_loop ? line_out_en : man_en;

  xs_port_serdes i_xs_port_serdes (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_data(blk_data), .blk_last(blk_last), .blk_src(blk_src), .blk_dst(blk_dst),
    .grant(grant), .epoch_start(epoch_start), .line_out(line_out),
    .line_out_en(line_out_en), .line_in(line_in), .line_in_en(line_in_en),
    .rx_valid(rx_valid), .rx_err(rx_err), .rx_payload(rx_payload),
    .rx_last(rx_last), .rx_src(rx_src), .rx_dst(rx_dst)
  );

  task automatic check(input string req, input string what,
                       input logic [UNIT-1:0] act, input logic [UNIT-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // unit layout per R5
  function automatic logic [UNIT-1:0] mk_unit(input logic [PAY-1:0] p, input logic l,
                                              input logic [3:0] s, input logic [3:0] d);
    logic [UNIT-1:0] u;
    u = '0;
    u[PAY-1:0] = p;
    for (int i = 0; i < 16; i++) u[1024+i] = ^p[64*i +: 64];
    u[1040] = 1'b1;
    u[1041] = l;
    u[1045:1042] = s;
    u[1049:1046] = d;
    return u;
  endfunction

  function automatic logic [PAY-1:0] mk_pay(input int seed);
    logic [PAY-1:0] p;
    for (int i = 0; i < 32; i++) p[32*i +: 32] = 32'(seed * 32'h9E3779B1 + i * 32'h01000193 + i);
    return p;
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic put_block(input logic [BLK-1:0] d, input logic l,
                           input logic [3:0] s, input logic [3:0] dd);
    @(negedge clk);
    blk_valid = 1'b1; blk_data = d; blk_last = l; blk_src = s; blk_dst = dd;
    while (!blk_ready) @(negedge clk);
    @(posedge clk);
    #1 blk_valid = 1'b0;
  endtask

  task automatic expect_unit(input logic [PAY-1:0] p, input logic l,
                             input logic [3:0] s, input logic [3:0] d, input logic e);
    rx_item_t it;
    tx_q.push_back(mk_unit(p, l, s, d));
    it.err = e; it.last = l; it.src = s; it.dst = d; it.pay = p;
    rx_q.push_back(it);
  endtask

  task automatic send_unit(input logic [PAY-1:0] p, input logic l,
                           input logic [3:0] s, input logic [3:0] d, input logic e);
    expect_unit(p, l, s, d, e);
    put_block(p[BLK-1:0], 1'b0, 4'h0, 4'h0);
    put_block(p[PAY-1:BLK], l, s, d);
  endtask

  task automatic drain();
    int n = 0;
    while ((tx_q.size() != 0 || rx_q.size() != 0) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    check("R7", "queues drained", UNIT'(tx_q.size() + rx_q.size()), '0);
  endtask

  // wire monitor: layout and burst shape on line_out
  logic [UNIT-1:0] cap;
  int beat = 0;
  logic prev_en = 1'b0, prev_es = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (line_out_en) begin
        en_cycles++;
        cur_run++;
        if (cur_run > max_run) max_run = cur_run;
        if (!prev_en) check("R4", "burst begins after epoch_start", UNIT'(prev_es), UNIT'(1));
        cap[beat*LANES +: LANES] = line_out;
        beat++;
        if (beat == TICKS) begin
          beat = 0;
          if (tx_q.size() == 0) check("R3", "unexpected transmission", UNIT'(1), UNIT'(0));
          else check("R5", "unit on wire", cap, tx_q.pop_front());
        end
      end else begin
        cur_run = 0;
        if (beat != 0) check("R4", "burst length", UNIT'(beat), UNIT'(TICKS));
        beat = 0;
        if (line_out !== '0) check("R10", "idle line zero", UNIT'(line_out), '0);
      end
    end
    prev_en = line_out_en;
    prev_es = epoch_start;
  end

  // receive monitor: scoreboard against expected items
  always @(negedge clk) begin
    if (rst_n && (rx_valid || rx_err)) begin
      if (rx_q.size() == 0) begin
        check("R7", "unexpected rx output", UNIT'({rx_valid, rx_err}), '0);
      end else begin
        rx_item_t e;
        e = rx_q.pop_front();
        if (e.err) begin
          check("R8", "rx_err on bad parity", UNIT'({rx_valid, rx_err}), UNIT'(2'b01));
        end else begin
          check("R7", "rx flags", UNIT'({rx_valid, rx_err}), UNIT'(2'b10));
          check("R7", "rx payload", UNIT'(rx_payload), UNIT'(e.pay));
          check("R7", "rx ctrl", UNIT'({rx_last, rx_src, rx_dst}), UNIT'({e.last, e.src, e.dst}));
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int bad, base;
    logic [UNIT-1:0] u;
    rst_n = 1'b0; blk_valid = 1'b0; blk_data = '0; blk_last = 1'b0;
    blk_src = '0; blk_dst = '0; grant = 1'b0; flip = '0; man_data = '0;
    man_en = 1'b0; use_loop = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "ready in reset", UNIT'(blk_ready), UNIT'(1));
    check("R10", "outputs quiet in reset",
          UNIT'({line_out_en, rx_valid, rx_err}), '0);
    rst_n = 1'b1;
    // R1 epoch strobe cadence, cycle 0 is the first after release
    bad = 0;
    for (int i = 0; i < 48; i++) begin
      if (epoch_start !== (i % 16 == 0)) bad++;
      @(negedge clk);
    end
    check("R1", "epoch_start cadence mismatches", UNIT'(bad), '0);

    // R3: one block only, grant high, nothing leaves
    grant = 1'b1;
    base = en_cycles;
    put_block(mk_pay(1)[BLK-1:0], 1'b0, 4'h0, 4'h0);
    repeat (40) @(negedge clk);
    check("R3", "half unit not sent", UNIT'(en_cycles - base), '0);
    check("R2", "ready with one block", UNIT'(blk_ready), UNIT'(1));
    expect_unit(mk_pay(1), 1'b1, 4'h3, 4'hC, 1'b0);
    put_block(mk_pay(1)[PAY-1:BLK], 1'b1, 4'h3, 4'hC);
    drain();

    // R2/R3: full unit held while grant low
    grant = 1'b0;
    base = en_cycles;
    send_unit('1, 1'b1, 4'hF, 4'h0, 1'b0);
    repeat (40) @(negedge clk);
    check("R2", "ready low while full", UNIT'(blk_ready), '0);
    check("R3", "no launch without grant", UNIT'(en_cycles - base), '0);
    grant = 1'b1;
    drain();
    send_unit('0, 1'b0, 4'h0, 4'hF, 1'b0);
    drain();

    // R6: three back-to-back units keep the line busy
    max_run = 0;
    send_unit(mk_pay(7), 1'b0, 4'h1, 4'h2, 1'b0);
    send_unit(mk_pay(8), 1'b0, 4'h4, 4'h8, 1'b0);
    send_unit(mk_pay(9), 1'b1, 4'hA, 4'h5, 1'b0);
    drain();
    check("R6", "continuous run of three units", UNIT'(max_run), UNIT'(48));

    // R8: lane 5 flipped on the receive path
    flip = LANES'(1) << 5;
    send_unit(mk_pay(11), 1'b0, 4'h6, 4'h9, 1'b1);
    drain();
    flip = '0;

    // R9: truncated burst then a clean unit on the manual path
    use_loop = 1'b0;
    u = mk_unit(mk_pay(21), 1'b1, 4'h7, 4'hE);
    begin
      rx_item_t it;
      it.err = 1'b0; it.last = 1'b1; it.src = 4'h7; it.dst = 4'hE; it.pay = mk_pay(21);
      rx_q.push_back(it);
    end
    for (int b = 0; b < 7; b++) begin
      @(negedge clk);
      man_en = 1'b1;
      man_data = LANES'(mk_pay(30 + b));
    end
    @(negedge clk);
    man_en = 1'b0;
    for (int b = 0; b < TICKS; b++) begin
      @(negedge clk);
      man_en = 1'b1;
      man_data = u[b*LANES +: LANES];
    end
    @(negedge clk);
    man_en = 1'b0;
    drain();
    use_loop = 1'b1;
    summary();
  end
endmodule